// File: doc/BRIEF.md
# CAN frame error detector

This block sits beside the bit stream of a CAN controller node and raises the five error classes defined for CAN 2.0B: bit, acknowledge, form, stuffing and CRC errors. A frame sequencer tells it, for each sampled bit, which part of the frame is on the wire. It also tells it whether that bit is an inserted stuff bit and whether the node is transmitting or receiving. The detector compares the level the node drove with the level it sampled. It counts runs of equal levels in stuffed regions, checks fixed-form fields for dominant bits, and compares the received CRC field against the locally computed one.

Each detected error appears as a one-cycle pulse on its own output in the cycle after the sample strobe. Errors that must be signalled on the bus also raise a one-cycle error-frame request. A missing acknowledge only pulses its own flag, so the controller can schedule a retransmission. Dominant is logic 0 and recessive is logic 1 on every bit input.

Top module: `can_err_detect`

## Requirements
- R1: While transmitting (tx_role_i=1), a strobed bit whose sampled level differs from the driven level raises bit_err_o; a receiving node never raises bit_err_o.
- R2: Driving recessive (1) and sampling dominant (0) raises no bit error while in_arb_i or in_ack_slot_i is 1; driving dominant and sampling recessive there still raises it.
- R3: While err_frame_tx_i and err_passive_i are both 1, a sampled dominant bit raises no bit error.
- R4: A transmitter whose ACK slot is sampled recessive raises ack_err_o without raising err_frame_req_o; a dominant ACK slot raises nothing.
- R5: A dominant bit sampled in the CRC delimiter, ACK delimiter, EOF or interframe space raises form_err_o; a recessive bit there raises nothing.
- R6: A dominant level in the last EOF bit (eof_last_i=1) is not a form error for a receiver but is one for a transmitter.
- R7: Inside a stuffed region, the sixth consecutive equal sampled level raises stuff_err_o; a level change restarts the run at one.
- R8: A bit marked as an inserted stuff bit restarts the run and counts as its first bit, so five further equal bits after it raise stuff_err_o and four do not.
- R9: A receiver compares the 15-bit received CRC with the computed CRC only when the CRC delimiter is strobed, and raises crc_err_o on inequality; a transmitter never raises it.
- R10: Every error output is a one-cycle pulse in the cycle after the strobe, and a cycle without a strobe raises nothing; err_frame_req_o pulses together with any bit, form, stuff or CRC error.
- R11: During and right after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | One-cycle strobe at each sample point |
| tx_bit_i | input | 1 | Level driven by this node |
| rx_bit_i | input | 1 | Level sampled from the bus |
| tx_role_i | input | 1 | 1 when this node transmits the frame |
| err_passive_i | input | 1 | Node is error passive |
| err_frame_tx_i | input | 1 | Node is sending an error frame |
| in_arb_i | input | 1 | Bit belongs to the arbitration field |
| in_ack_slot_i | input | 1 | Bit is the ACK slot |
| in_crc_dlm_i | input | 1 | Bit is the CRC delimiter |
| in_ack_dlm_i | input | 1 | Bit is the ACK delimiter |
| in_eof_i | input | 1 | Bit belongs to end of frame |
| eof_last_i | input | 1 | Bit is the last EOF bit |
| in_ifs_i | input | 1 | Bit belongs to the interframe space |
| in_stuffed_i | input | 1 | Bit lies in a stuffed region |
| stuff_bit_i | input | 1 | Bit is an inserted stuff bit |
| crc_rx_i | input | 15 | Received CRC field |
| crc_calc_i | input | 15 | Locally computed CRC |
| bit_err_o | output | 1 | Bit error pulse |
| ack_err_o | output | 1 | Acknowledge error pulse |
| form_err_o | output | 1 | Form error pulse |
| stuff_err_o | output | 1 | Stuffing error pulse |
| crc_err_o | output | 1 | CRC error pulse |
| err_frame_req_o | output | 1 | Error-frame request pulse |

## Verification
The only internal state is the equal-level run counter and its last level. A wrong count or a missed restart shows as a stuff_err_o pulse one bit early or late, one cycle after the offending strobe. A pulse on the wrong exception path shows on bit_err_o, form_err_o or err_frame_req_o in the cycle after the strobe. The directed cases place bits on both sides of each run limit and each exception so that such shifts change an observed pulse.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam logic DOM = 1'b0;
  localparam logic REC = 1'b1;

  typedef struct packed {
    logic crc_e;
    logic stuff_e;
    logic form_e;
    logic ack_e;
    logic bit_e;
  } err_vec_t;
endpackage

// File: rtl/can_bit_mon.sv
module can_bit_mon
  import can_err_pkg::*;
(
  input  logic bit_stb_i,
  input  logic tx_bit_i,
  input  logic rx_bit_i,
  input  logic tx_role_i,
  input  logic err_passive_i,
  input  logic err_frame_tx_i,
  input  logic in_arb_i,
  input  logic in_ack_slot_i,
  output logic bit_err_o,
  output logic ack_err_o
);
  logic mismatch, rec_over, rec_excused, passive_excused;

  always_comb begin
    mismatch        = tx_bit_i != rx_bit_i;
    rec_over        = (tx_bit_i == REC) && (rx_bit_i == DOM);
    rec_excused     = rec_over && (in_arb_i || in_ack_slot_i);
    passive_excused = err_frame_tx_i && err_passive_i && (rx_bit_i == DOM);
    bit_err_o = bit_stb_i && tx_role_i && mismatch && !rec_excused && !passive_excused;
    ack_err_o = bit_stb_i && tx_role_i && in_ack_slot_i && (rx_bit_i == REC);
  end
endmodule

// File: rtl/can_stuff_mon.sv
module can_stuff_mon #(
  parameter int unsigned RUN_LIMIT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_stb_i,
  input  logic rx_bit_i,
  input  logic in_stuffed_i,
  input  logic stuff_bit_i,
  output logic stuff_err_o
);
  localparam int unsigned RUN_W = $clog2(RUN_LIMIT + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LIMIT);
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

  logic [RUN_W-1:0] run_q, run_d;
  logic             lvl_q, lvl_d;
  logic             same;

  always_comb begin
    same        = (run_q != '0) && (rx_bit_i == lvl_q);
    stuff_err_o = bit_stb_i && in_stuffed_i && same && (run_q == RUN_MAX);
    run_d       = run_q;
    lvl_d       = lvl_q;
    if (bit_stb_i) begin
      lvl_d = rx_bit_i;
      if (!in_stuffed_i)                  run_d = '0;
      else if (stuff_bit_i || !same)      run_d = RUN_ONE;
      else if (stuff_err_o)               run_d = RUN_ONE;
      else                                run_d = run_q + RUN_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      lvl_q <= 1'b1;
    end else begin
      run_q <= run_d;
      lvl_q <= lvl_d;
    end
  end
endmodule

// File: rtl/can_form_crc_mon.sv
module can_form_crc_mon
  import can_err_pkg::*;
#(
  parameter int unsigned CRC_W = 15
) (
  input  logic             bit_stb_i,
  input  logic             rx_bit_i,
  input  logic             tx_role_i,
  input  logic             in_crc_dlm_i,
  input  logic             in_ack_dlm_i,
  input  logic             in_eof_i,
  input  logic             eof_last_i,
  input  logic             in_ifs_i,
  input  logic [CRC_W-1:0] crc_rx_i,
  input  logic [CRC_W-1:0] crc_calc_i,
  output logic             form_err_o,
  output logic             crc_err_o
);
  logic fixed_fld, rx_eof_waiver;

  always_comb begin
    fixed_fld     = in_crc_dlm_i || in_ack_dlm_i || in_eof_i || in_ifs_i;
    rx_eof_waiver = !tx_role_i && in_eof_i && eof_last_i;
    form_err_o    = bit_stb_i && fixed_fld && (rx_bit_i == DOM) && !rx_eof_waiver;
    crc_err_o     = bit_stb_i && !tx_role_i && in_crc_dlm_i && (crc_rx_i != crc_calc_i);
  end
endmodule

// File: rtl/can_err_detect.sv
module can_err_detect
  import can_err_pkg::*;
#(
  parameter int unsigned CRC_W     = 15,
  parameter int unsigned RUN_LIMIT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_stb_i,
  input  logic             tx_bit_i,
  input  logic             rx_bit_i,
  input  logic             tx_role_i,
  input  logic             err_passive_i,
  input  logic             err_frame_tx_i,
  input  logic             in_arb_i,
  input  logic             in_ack_slot_i,
  input  logic             in_crc_dlm_i,
  input  logic             in_ack_dlm_i,
  input  logic             in_eof_i,
  input  logic             eof_last_i,
  input  logic             in_ifs_i,
  input  logic             in_stuffed_i,
  input  logic             stuff_bit_i,
  input  logic [CRC_W-1:0] crc_rx_i,
  input  logic [CRC_W-1:0] crc_calc_i,
  output logic             bit_err_o,
  output logic             ack_err_o,
  output logic             form_err_o,
  output logic             stuff_err_o,
  output logic             crc_err_o,
  output logic             err_frame_req_o
);
  err_vec_t det, err_q;
  logic     req_q;

  can_bit_mon u_bit (
    .bit_stb_i      (bit_stb_i),
    .tx_bit_i       (tx_bit_i),
    .rx_bit_i       (rx_bit_i),
    .tx_role_i      (tx_role_i),
    .err_passive_i  (err_passive_i),
    .err_frame_tx_i (err_frame_tx_i),
    .in_arb_i       (in_arb_i),
    .in_ack_slot_i  (in_ack_slot_i),
    .bit_err_o      (det.bit_e),
    .ack_err_o      (det.ack_e)
  );

  can_stuff_mon #(.RUN_LIMIT(RUN_LIMIT)) u_stuff (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_stb_i    (bit_stb_i),
    .rx_bit_i     (rx_bit_i),
    .in_stuffed_i (in_stuffed_i),
    .stuff_bit_i  (stuff_bit_i),
    .stuff_err_o  (det.stuff_e)
  );

  can_form_crc_mon #(.CRC_W(CRC_W)) u_form (
    .bit_stb_i    (bit_stb_i),
    .rx_bit_i     (rx_bit_i),
    .tx_role_i    (tx_role_i),
    .in_crc_dlm_i (in_crc_dlm_i),
    .in_ack_dlm_i (in_ack_dlm_i),
    .in_eof_i     (in_eof_i),
    .eof_last_i   (eof_last_i),
    .in_ifs_i     (in_ifs_i),
    .crc_rx_i     (crc_rx_i),
    .crc_calc_i   (crc_calc_i),
    .form_err_o   (det.form_e),
    .crc_err_o    (det.crc_e)
  );

  // acknowledge miss is retried, not signalled with an error frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
      req_q <= 1'b0;
    end else begin
      err_q <= det;
      req_q <= det.bit_e | det.form_e | det.stuff_e | det.crc_e;
    end
  end

  assign bit_err_o       = err_q.bit_e;
  assign ack_err_o       = err_q.ack_e;
  assign form_err_o      = err_q.form_e;
  assign stuff_err_o     = err_q.stuff_e;
  assign crc_err_o       = err_q.crc_e;
  assign err_frame_req_o = req_q;
endmodule

// File: rtl/can_err_detect_chk.sv
module can_err_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_stb_i,
  input logic tx_role_i,
  input logic rx_bit_i,
  input logic in_ack_slot_i,
  input logic in_crc_dlm_i,
  input logic in_stuffed_i,
  input logic bit_err_o,
  input logic ack_err_o,
  input logic form_err_o,
  input logic stuff_err_o,
  input logic crc_err_o,
  input logic err_frame_req_o
);
  AST_BIT_TX_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_err_o |-> $past(tx_role_i) && $past(bit_stb_i)); // R1
  AST_ACK_SLOT_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_err_o |-> $past(in_ack_slot_i) && $past(rx_bit_i) && $past(tx_role_i)); // R4
  AST_ACK_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_err_o && !bit_err_o && !form_err_o && !stuff_err_o && !crc_err_o) |-> !err_frame_req_o); // R4
  AST_FORM_DOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    form_err_o |-> !$past(rx_bit_i)); // R5
  AST_STUFF_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_err_o |-> $past(in_stuffed_i) && $past(bit_stb_i)); // R7
  AST_CRC_AT_DLM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_o |-> $past(in_crc_dlm_i) && !$past(tx_role_i)); // R9
  AST_REQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_err_o || form_err_o || stuff_err_o || crc_err_o) |-> err_frame_req_o); // R10
  AST_NO_STB_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_i |=> !err_frame_req_o && !ack_err_o); // R10
endmodule

bind can_err_detect can_err_detect_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .bit_stb_i       (bit_stb_i),
  .tx_role_i       (tx_role_i),
  .rx_bit_i        (rx_bit_i),
  .in_ack_slot_i   (in_ack_slot_i),
  .in_crc_dlm_i    (in_crc_dlm_i),
  .in_stuffed_i    (in_stuffed_i),
  .bit_err_o       (bit_err_o),
  .ack_err_o       (ack_err_o),
  .form_err_o      (form_err_o),
  .stuff_err_o     (stuff_err_o),
  .crc_err_o       (crc_err_o),
  .err_frame_req_o (err_frame_req_o)
);

// File: tb/sim_can_err_detect.sv
`timescale 1ns/1ps
module sim_can_err_detect;
  localparam logic [5:0] NONE = 6'b000000;
  localparam logic [5:0] E_BIT = 6'b100001;
  localparam logic [5:0] E_ACK = 6'b000010;
  localparam logic [5:0] E_FRM = 6'b100100;
  localparam logic [5:0] E_STF = 6'b101000;
  localparam logic [5:0] E_CRC = 6'b110000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stb = 0, txb = 1, rxb = 1, role = 0, passive = 0, eftx = 0;
  logic arb = 0, ackslot = 0, crcdlm = 0, ackdlm = 0, eof = 0, eoflast = 0;
  logic ifs = 0, stuffed = 0, sbit = 0;
  logic [14:0] crc_rx = '0, crc_calc = '0;
  logic bit_e, ack_e, form_e, stuff_e, crc_e, req;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  can_err_detect u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_stb_i(stb), .tx_bit_i(txb), .rx_bit_i(rxb),
    .tx_role_i(role), .err_passive_i(passive), .err_frame_tx_i(eftx),
    .in_arb_i(arb), .in_ack_slot_i(ackslot), .in_crc_dlm_i(crcdlm),
    .in_ack_dlm_i(ackdlm), .in_eof_i(eof), .eof_last_i(eoflast), .in_ifs_i(ifs),
    .in_stuffed_i(stuffed), .stuff_bit_i(sbit), .crc_rx_i(crc_rx),
    .crc_calc_i(crc_calc), .bit_err_o(bit_e), .ack_err_o(ack_e),
    .form_err_o(form_e), .stuff_err_o(stuff_e), .crc_err_o(crc_e),
    .err_frame_req_o(req)
  );

  task automatic chk(input logic [5:0] exp, input string tag);
    logic [5:0] got;
    got = {req, crc_e, stuff_e, form_e, ack_e, bit_e};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b exp=%b", tag, got, exp);
    end
  endtask

  // {req,crc,stuff,form,ack,bit}, checked one cycle after the strobe
  task automatic step(input logic tx, input logic rx, input logic [5:0] exp, input string tag);
    txb = tx; rxb = rx; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    chk(exp, tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    chk(NONE, tag);
  endtask

  task automatic clr();
    role = 0; passive = 0; eftx = 0; arb = 0; ackslot = 0; crcdlm = 0; ackdlm = 0;
    eof = 0; eoflast = 0; ifs = 0; stuffed = 0; sbit = 0; crc_rx = '0; crc_calc = '0;
  endtask

  task automatic t_reset();
    chk(NONE, "R11 in reset");
    @(negedge clk); rst_n = 1'b1;
    idle("R11 after reset");
  endtask

  task automatic t_bit();
    clr(); role = 1;
    step(1, 0, E_BIT, "R1 rec->dom");
    idle("R10 pulse ends");
    step(0, 1, E_BIT, "R1 dom->rec");
    step(1, 1, NONE, "R1 match");
    role = 0;
    step(1, 0, NONE, "R1 receiver");
  endtask

  task automatic t_arb();
    clr(); role = 1; arb = 1;
    step(1, 0, NONE, "R2 arb lost");
    step(0, 1, E_BIT, "R2 arb dom->rec");
    arb = 0; ackslot = 1;
    step(1, 0, NONE, "R2 ack slot");
  endtask

  task automatic t_passive();
    clr(); role = 1; eftx = 1; passive = 1;
    step(1, 0, NONE, "R3 passive flag");
    passive = 0;
    step(1, 0, E_BIT, "R3 active flag");
  endtask

  task automatic t_ack();
    clr(); role = 1; ackslot = 1;
    step(1, 1, E_ACK, "R4 no ack");
    step(1, 0, NONE, "R4 acked");
  endtask

  task automatic t_form();
    clr();
    crcdlm = 1; step(1, 0, E_FRM, "R5 crc dlm"); step(1, 1, NONE, "R5 crc dlm rec"); crcdlm = 0;
    ackdlm = 1; step(1, 0, E_FRM, "R5 ack dlm"); ackdlm = 0;
    eof = 1;    step(1, 0, E_FRM, "R5 eof");     step(1, 1, NONE, "R5 eof rec");
    eoflast = 1;
    step(1, 0, NONE, "R6 rx last eof");
    role = 1;
    step(1, 0, E_FRM | E_BIT, "R6 tx last eof");
    role = 0; eof = 0; eoflast = 0;
    ifs = 1;    step(1, 0, E_FRM, "R5 ifs"); ifs = 0;
  endtask

  task automatic t_stuff();
    clr(); stuffed = 1;
    step(1, 1, NONE, "R7 lead");
    for (int i = 0; i < 5; i++) step(0, 0, NONE, "R7 run<=5");
    step(0, 0, E_STF, "R7 sixth");
    stuffed = 0; step(1, 1, NONE, "R7 leave"); stuffed = 1;
    for (int i = 0; i < 5; i++) step(0, 0, NONE, "R7 zeros");
    step(1, 1, NONE, "R7 change");
    for (int i = 0; i < 4; i++) step(1, 1, NONE, "R7 ones");
    step(0, 0, NONE, "R7 change back");
    stuffed = 0; step(1, 1, NONE, "R8 leave"); stuffed = 1;
    for (int i = 0; i < 5; i++) step(0, 0, NONE, "R8 zeros");
    sbit = 1; step(1, 1, NONE, "R8 stuff bit"); sbit = 0;
    for (int i = 0; i < 4; i++) step(1, 1, NONE, "R8 run after stuff");
    step(1, 1, E_STF, "R8 sixth incl stuff");
    stuffed = 0; step(1, 1, NONE, "R8 leave2"); stuffed = 1;
    for (int i = 0; i < 5; i++) step(1, 1, NONE, "R8 ones");
    sbit = 1; step(1, 1, E_STF, "R8 bad stuff bit"); sbit = 0;
    stuffed = 0;
  endtask

  task automatic t_crc();
    clr(); crc_rx = 15'h1234; crc_calc = 15'h1235;
    step(1, 1, NONE, "R9 outside dlm");
    crcdlm = 1;
    step(1, 1, E_CRC, "R9 mismatch");
    role = 1;
    step(1, 1, NONE, "R9 transmitter");
    role = 0; crc_calc = 15'h1234;
    step(1, 1, NONE, "R9 match");
    crc_calc = 15'h5234;
    stb = 0; idle("R10 no strobe");
    crcdlm = 0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_bit();
    t_arb();
    t_passive();
    t_ack();
    t_form();
    t_stuff();
    t_crc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog: got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule